// File: doc/BRIEF.md
# Gated Edge Phase Detector

This block sits at the front of an all-digital clock recovery loop. It watches a sparse serial data line for rising transitions and compares each one against the recovered-clock phase count. From that comparison it produces a one-cycle up or down request for the loop filter that follows. Everything runs on a single fast system clock. The raw data line is synchronized first. The recovered cell position is supplied as a divider phase count, together with the half-cell length.

Each captured transition opens a delay window of half a recovered cell. The strobe for that transition is issued only when the window closes. A cell with no transition therefore produces no request at all, so gaps of several cells between data pulses leave the loop untouched. Jitter of up to half a cell either way still maps onto a definite direction. The direction depends on which half of the cell the transition fell into. Every qualifying transition yields exactly one strobe, which gives a detector gain of one.

Top module: `gated_phase_det`

## Requirements
- R1: While rst_ni is low and after it is released, up_o and dn_o stay low until a rising transition of data_i has been captured.
- R2: Only a low-to-high change of data_i counts as a transition. A level held high for any number of cycles counts once, and a falling change counts as nothing.
- R3: A rising transition of data_i first sampled high at clock edge k is captured at edge k+2. Its strobe is high for the cycle that follows edge k+2+H. H is half_i as sampled at edge k+2, with a value of 0 treated as 1.
- R4: If phase_i sampled at the capture edge is below H, the strobe is dn_o. Otherwise it is up_o.
- R5: up_o and dn_o are never high together, and each is high for one cycle at a time.
- R6: With no rising transition on data_i, no strobe is ever issued, however many cells pass.
- R7: A transition that reaches the capture point while a window is open is dropped and produces no strobe. The window is open from the capture edge up to and including the edge that registers the strobe.
- R8: After a capture, no further capture happens in the same cell. A new cell begins at an edge where phase_i is 0, and a transition reaching the capture point at that edge is accepted.
- R9: A change of phase_i or half_i after the capture edge does not change that strobe's direction or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Raw serial data line, asynchronous |
| phase_i | input | PW | Recovered-cell phase count, 0 at cell start |
| half_i | input | PW | Half-cell length in clock cycles |
| up_o | output | 1 | One-cycle request: transition in the late half of the cell |
| dn_o | output | 1 | One-cycle request: transition in the early half of the cell |

## Verification
Two functions can meet in the same cycle. The first is the closing of a window, which registers a strobe. The second is the arrival of a new transition at the capture point, or the cell boundary at phase 0 coinciding with a capture. The bench places transitions so that they reach capture on the exact edge where the window closes, and on the edge where phase_i is 0 right after a capture in the previous cell. A bench model built from R3, R7 and R8 judges these cases: the first transition must be dropped, and the second must be accepted. The same model checks every cycle of randomly spaced pulses.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_NONE = 2'd0,
    PD_DN   = 2'd1,
    PD_UP   = 2'd2
  } pd_dir_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= data_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign edge_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pd_decide.sv
module pd_decide
  import pd_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [PW-1:0] phase_i,
  input  logic [PW-1:0] half_i,
  output pd_dir_e       dir_o
);
  // early half of the cell -> slow down, late half -> speed up
  always_comb dir_o = (phase_i >= half_i) ? PD_UP : PD_DN;
endmodule

// File: rtl/pd_window.sv
module pd_window
  import pd_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic [PW-1:0] phase_i,
  input  logic [PW-1:0] half_i,
  input  pd_dir_e       dir_i,
  output logic          acc_o,
  output logic          fire_o,
  output pd_dir_e       dir_o
);
  logic          pend_q, used_q, fire_q;
  logic [PW-1:0] cnt_q;
  pd_dir_e       dir_q;
  logic          ph_zero;

  assign ph_zero = (phase_i == '0);
  // one capture per cell, none while a window is open
  assign acc_o   = edge_i & ~pend_q & (~used_q | ph_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      used_q <= 1'b0;
      fire_q <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= PD_NONE;
    end else begin
      fire_q <= pend_q && (cnt_q == PW'(1));
      if (acc_o) begin
        pend_q <= 1'b1;
        cnt_q  <= half_i;
        dir_q  <= dir_i;
      end else if (pend_q) begin
        if (cnt_q == PW'(1)) pend_q <= 1'b0;
        else                 cnt_q  <= cnt_q - PW'(1);
      end
      if (acc_o)        used_q <= 1'b1;
      else if (ph_zero) used_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gated_phase_det.sv
module gated_phase_det
  import pd_pkg::*;
#(
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_i,
  input  logic [PW-1:0] phase_i,
  input  logic [PW-1:0] half_i,
  output logic          up_o,
  output logic          dn_o
);
  logic          edge_pulse;
  logic          acc;
  logic          fire;
  logic [PW-1:0] half_eff;
  pd_dir_e       dir_now, dir_held;

  assign half_eff = (half_i == '0) ? PW'(1) : half_i;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .edge_o (edge_pulse)
  );

  pd_decide #(.PW(PW)) u_decide (
    .phase_i (phase_i),
    .half_i  (half_eff),
    .dir_o   (dir_now)
  );

  pd_window #(.PW(PW)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_pulse),
    .phase_i (phase_i),
    .half_i  (half_eff),
    .dir_i   (dir_now),
    .acc_o   (acc),
    .fire_o  (fire),
    .dir_o   (dir_held)
  );

  assign up_o = fire & (dir_held == PD_UP);
  assign dn_o = fire & (dir_held == PD_DN);
endmodule

// File: rtl/gpd_checker.sv
module gpd_checker #(
  parameter int PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          up_o,
  input logic          dn_o,
  input logic          edge_pulse,
  input logic          acc,
  input logic [PW-1:0] half_eff
);
  logic          armed_q;
  logic [PW-1:0] win_q;
  logic          strobe;

  assign strobe = up_o | dn_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     armed_q <= 1'b0;
    else if (strobe) armed_q <= edge_pulse;
    else             armed_q <= armed_q | edge_pulse;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          win_q <= '0;
    else if (acc)         win_q <= half_eff;
    else if (win_q != '0) win_q <= win_q - PW'(1);

  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
  a_r5_up_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |=> !up_o);
  a_r5_dn_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |=> !dn_o);
  a_r6_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> armed_q);
  a_r3_fires_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == PW'(1)) |=> strobe);
  a_r3_no_early_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> ($past(win_q) == PW'(1)));
endmodule

bind gated_phase_det gpd_checker #(.PW(PW)) u_gpd_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .edge_pulse (edge_pulse),
  .acc        (acc),
  .half_eff   (half_eff)
);

// File: tb/gated_phase_det_bench.sv
`timescale 1ns/1ps
module gated_phase_det_bench;
  localparam int PW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          data_i = 1'b0;
  logic [PW-1:0] phase_i = '0;
  logic [PW-1:0] half_i = '0;
  logic          up_o, dn_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // cell stimulus
  int per = 20;
  int ph  = 0;
  int hv  = 10;

  // reference model state
  bit d0, d1, d2, d3;
  bit m_pend, m_used, m_late;
  int m_cd;
  bit exp_up, exp_dn;
  string m_why = "R6";
  int n_strobes = 0;

  gated_phase_det #(.PW(PW)) u_gated_phase_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .phase_i(phase_i), .half_i(half_i), .up_o(up_o), .dn_o(dn_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic model_reset();
    d0 = 0; d1 = 0; d2 = 0; d3 = 0;
    m_pend = 0; m_used = 0; m_late = 0; m_cd = 0;
    exp_up = 0; exp_dn = 0; m_why = "R6";
  endtask

  // one clock edge of the requirement-level model (R3, R4, R7, R8, R9)
  task automatic model_edge(input bit dv, input int pv, input int hvv);
    bit edge_seen, fire, acc;
    int heff;
    d3 = d2; d2 = d1; d1 = d0; d0 = dv;
    edge_seen = d2 & ~d3;
    fire = m_pend && (m_cd == 1);
    acc = edge_seen && !m_pend && (!m_used || pv == 0);
    if (edge_seen && !acc) m_why = m_pend ? "R7" : "R8";
    exp_up = fire && m_late;
    exp_dn = fire && !m_late;
    if (fire) m_pend = 0;
    else if (m_pend) m_cd--;
    if (acc) begin
      heff = (hvv == 0) ? 1 : hvv;
      m_pend = 1; m_cd = heff; m_late = (pv >= heff);
      m_why = "R6";
    end
    if (acc) m_used = 1;
    else if (pv == 0) m_used = 0;
  endtask

  task automatic step(input bit d);
    int pv, hvv;
    pv = ph; hvv = hv;
    data_i = d; phase_i = PW'(pv); half_i = PW'(hvv);
    @(posedge clk_i);
    model_edge(d, pv, hvv);
    @(negedge clk_i);
    checks++;
    if (up_o !== exp_up || dn_o !== exp_dn) begin
      errors++;
      $display("FAIL %s: actual up=%0b dn=%0b expected up=%0b dn=%0b",
               (exp_up || exp_dn) ? "R3 R4" : m_why, up_o, dn_o, exp_up, exp_dn);
    end
    if (up_o || dn_o) begin
      n_strobes++;
      checks++;
      if (up_o && dn_o) begin
        errors++;
        $display("FAIL R5: actual up=1 dn=1 expected one of them");
      end
    end
    ph = (ph + 1) % per;
  endtask

  task automatic run(input bit d, input int n);
    for (int i = 0; i < n; i++) step(d);
  endtask

  // step until the next step presents phase p
  task automatic goto_phase(input bit d, input int p);
    while (ph != p) step(d);
  endtask

  task automatic set_cell(input int p, input int h);
    per = p; hv = h; ph = 0;
  endtask

  task automatic expect_count(input string tag, input int got, input int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: actual strobes %0d expected %0d", tag, got, want);
    end
  endtask

  initial begin
    int s0;
    s0 = $urandom(32'h5EED_0017);
    model_reset();
    repeat (4) @(negedge clk_i);
    checks++;
    if (up_o !== 1'b0 || dn_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual up=%0b dn=%0b expected 0 0 in reset", up_o, dn_o);
    end
    rst_ni = 1'b1;

    // R1, R6: idle line over many cells
    set_cell(20, 10);
    n_strobes = 0;
    run(0, 200);
    expect_count("R6", n_strobes, 0);

    // R2: long high level gives one strobe; falling change gives none
    n_strobes = 0;
    run(1, 80);
    run(0, 80);
    expect_count("R2", n_strobes, 1);

    // R4: capture at phase 3 (early) then at phase 15 of a later cell (late)
    set_cell(20, 10);
    run(0, 20);
    n_strobes = 0;
    goto_phase(0, 1); run(1, 2); run(0, 30);
    goto_phase(0, 13); run(1, 2); run(0, 30);
    expect_count("R4", n_strobes, 2);

    // R3: half-cell of 1 and of 0 (treated as 1)
    set_cell(8, 1);
    run(0, 8);
    goto_phase(0, 2); run(1, 1); run(0, 10);
    set_cell(8, 0);
    run(0, 8);
    goto_phase(0, 6); run(1, 1); run(0, 10);

    // R8: second capture in the same cell dropped, capture at phase 0 accepted
    set_cell(20, 4);
    run(0, 20);
    n_strobes = 0;
    goto_phase(0, 0); run(1, 1); run(0, 1);   // captured at phase 2
    goto_phase(0, 8); run(1, 1); run(0, 1);   // reaches capture at phase 10: dropped
    goto_phase(0, 18); run(1, 1); run(0, 1);  // reaches capture at phase 0: accepted
    run(0, 20);
    expect_count("R8", n_strobes, 2);

    // R7: transition reaching capture on the edge the window closes
    set_cell(40, 6);
    run(0, 40);
    n_strobes = 0;
    goto_phase(0, 0); run(1, 1); run(0, 1);   // capture at phase 2, fires at phase 8
    goto_phase(0, 6); run(1, 1); run(0, 1);   // capture point at phase 8: dropped
    run(0, 40);
    expect_count("R7", n_strobes, 1);

    // R9: inputs change during an open window
    set_cell(30, 12);
    run(0, 30);
    n_strobes = 0;
    goto_phase(0, 1); run(1, 1);               // capture at phase 3, early
    hv = 2; run(0, 4);
    hv = 25; run(0, 30);
    expect_count("R9", n_strobes, 1);

    // randomized spacing, widths and cell lengths
    for (int seg = 0; seg < 40; seg++) begin
      int p;
      p = 4 + int'($urandom_range(36));
      set_cell(p, ($urandom_range(5) == 0) ? int'($urandom_range(p)) : p / 2);
      for (int k = 0; k < 12; k++) begin
        run(0, int'($urandom_range(4 * p)));
        run(1, 1 + int'($urandom_range(3)));
      end
      run(0, 2 * p);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule